// File: doc/BRIEF.md
# Integer ALU with Overflow Trap

This block is the integer execute stage of a 32-bit load/store core. Each cycle it may accept one instruction, already split into its primary opcode, its rt index and its low 16 bits, together with two operand values read from the register file upstream. One clock later it presents the computed value, the destination register index, a write-enable and an arithmetic-overflow trap flag.

The block handles register-register add and subtract in both a trapping and a wrapping flavour, the three bitwise operations, and the immediate forms of add (trapping and wrapping), AND, OR and XOR. The trapping and wrapping flavours share a single adder. When a trapping form overflows in the signed sense, the trap flag rises and the write is withheld, so the destination register keeps its old value. Any other encoding produces an output beat that writes nothing and traps nothing.

Top module: `exu_alu`

## Requirements
- R1: While rst_n is low and in the cycle after it rises, out_valid, wr_en and ovf_trap are 0.
- R2: Opcode 0 with function code 0x20 (trapping add) gives result = opnd_a + opnd_b mod 2^32 and writes register rd (insn_low[15:11]); on signed overflow ovf_trap is 1 and wr_en is 0.
- R3: Opcode 0 with function code 0x21 (wrapping add) writes rd with opnd_a + opnd_b mod 2^32 and never raises ovf_trap.
- R4: Opcode 0 with function code 0x22 (trapping subtract) gives opnd_a - opnd_b mod 2^32 into rd and traps on signed overflow with wr_en 0; function code 0x23 (wrapping subtract) writes the same difference and never traps.
- R5: Opcode 0 with function codes 0x24, 0x25 and 0x26 writes rd with the bitwise AND, OR and XOR of the operands and never traps.
- R6: Opcode 8 (trapping add immediate) writes register rt (insn_rt) with opnd_a plus the sign-extended insn_low, traps on signed overflow with wr_en 0.
- R7: Opcode 9 (wrapping add immediate) writes rt with opnd_a plus the sign-extended insn_low mod 2^32 and never traps.
- R8: Opcodes 12, 13 and 14 write rt with the AND, OR and XOR of opnd_a and the zero-extended insn_low, and never trap.
- R9: Any other opcode, or opcode 0 with a function code (insn_low[5:0]) outside 0x20..0x26, gives out_valid 1 with wr_en 0 and ovf_trap 0.
- R10: A cycle with in_valid low yields out_valid, wr_en and ovf_trap all 0 one cycle later, whatever the other inputs hold.
- R11: Every output reflects the inputs sampled at the previous rising clock edge: exactly one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An instruction is presented this cycle |
| insn_op | input | 6 | Primary opcode (instruction bits 31:26) |
| insn_rt | input | 5 | rt field (instruction bits 20:16), destination of immediate forms |
| insn_low | input | 16 | Instruction bits 15:0: immediate, or rd/shamt/function code |
| opnd_a | input | DATA_W | Value of register rs |
| opnd_b | input | DATA_W | Value of register rt (register-register forms) |
| out_valid | output | 1 | A result beat is present |
| wr_en | output | 1 | Write result to wr_idx |
| wr_idx | output | 5 | Destination register index |
| result | output | DATA_W | Computed value |
| ovf_trap | output | 1 | Signed-overflow exception on a trapping form |

## Verification
The bench builds the block with its default parameters, DATA_W = 32 and IMM_W = 16, so the operand edges 0x7fffffff and 0x80000000 and the immediate sign bit 0x8000 sit exactly where the trap and sign-extension rules act. Operands are drawn with a bias toward those edges so the trapping and wrapping flavours meet both sides of the overflow boundary, and the zero-extended immediates are driven with their top bit set to separate them from the sign-extended ones.

// File: rtl/exu_pkg.sv
package exu_pkg;

  localparam int OPC_W  = 6;
  localparam int FUNC_W = 6;
  localparam int RIDX_W = 5;

  typedef enum logic [2:0] {
    K_NONE = 3'd0,
    K_ADD  = 3'd1,
    K_SUB  = 3'd2,
    K_AND  = 3'd3,
    K_OR   = 3'd4,
    K_XOR  = 3'd5
  } alu_kind_e;

  typedef struct packed {
    logic              legal;
    logic              trap_en;
    logic              use_imm;
    logic              imm_sext;
    alu_kind_e         kind;
    logic [RIDX_W-1:0] dst;
  } dec_t;

  // primary opcodes
  localparam logic [OPC_W-1:0] OPC_REG   = 6'd0;
  localparam logic [OPC_W-1:0] OPC_ADDT  = 6'd8;
  localparam logic [OPC_W-1:0] OPC_ADDW  = 6'd9;
  localparam logic [OPC_W-1:0] OPC_ANDI  = 6'd12;
  localparam logic [OPC_W-1:0] OPC_ORI   = 6'd13;
  localparam logic [OPC_W-1:0] OPC_XORI  = 6'd14;

  // register-register function codes
  localparam logic [FUNC_W-1:0] FN_ADDT = 6'h20;
  localparam logic [FUNC_W-1:0] FN_ADDW = 6'h21;
  localparam logic [FUNC_W-1:0] FN_SUBT = 6'h22;
  localparam logic [FUNC_W-1:0] FN_SUBW = 6'h23;
  localparam logic [FUNC_W-1:0] FN_AND  = 6'h24;
  localparam logic [FUNC_W-1:0] FN_OR   = 6'h25;
  localparam logic [FUNC_W-1:0] FN_XOR  = 6'h26;

endpackage

// File: rtl/exu_decode.sv
module exu_decode
  import exu_pkg::*;
(
  input  logic [OPC_W-1:0]  op,
  input  logic [FUNC_W-1:0] func,
  input  logic [RIDX_W-1:0] rt,
  input  logic [RIDX_W-1:0] rd,
  output dec_t              dec
);

  always_comb begin
    dec          = '0;
    dec.kind     = K_NONE;
    unique case (op)
      OPC_REG: begin
        dec.dst = rd;
        unique case (func)
          FN_ADDT: begin dec.legal = 1'b1; dec.kind = K_ADD; dec.trap_en = 1'b1; end
          FN_ADDW: begin dec.legal = 1'b1; dec.kind = K_ADD; end
          FN_SUBT: begin dec.legal = 1'b1; dec.kind = K_SUB; dec.trap_en = 1'b1; end
          FN_SUBW: begin dec.legal = 1'b1; dec.kind = K_SUB; end
          FN_AND:  begin dec.legal = 1'b1; dec.kind = K_AND; end
          FN_OR:   begin dec.legal = 1'b1; dec.kind = K_OR;  end
          FN_XOR:  begin dec.legal = 1'b1; dec.kind = K_XOR; end
          default: ;
        endcase
      end
      OPC_ADDT: begin
        dec.dst = rt; dec.legal = 1'b1; dec.kind = K_ADD;
        dec.trap_en = 1'b1; dec.use_imm = 1'b1; dec.imm_sext = 1'b1;
      end
      OPC_ADDW: begin
        dec.dst = rt; dec.legal = 1'b1; dec.kind = K_ADD;
        dec.use_imm = 1'b1; dec.imm_sext = 1'b1;
      end
      OPC_ANDI: begin dec.dst = rt; dec.legal = 1'b1; dec.kind = K_AND; dec.use_imm = 1'b1; end
      OPC_ORI:  begin dec.dst = rt; dec.legal = 1'b1; dec.kind = K_OR;  dec.use_imm = 1'b1; end
      OPC_XORI: begin dec.dst = rt; dec.legal = 1'b1; dec.kind = K_XOR; dec.use_imm = 1'b1; end
      default: ;
    endcase
  end

endmodule

// File: rtl/exu_addsub.sv
module exu_addsub #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              sub,
  output logic [DATA_W-1:0] sum,
  output logic              sovf
);

  localparam int MSB = DATA_W - 1;

  function automatic logic [DATA_W-1:0] add_carry(
    input logic [DATA_W-1:0] x, input logic [DATA_W-1:0] y, input logic cin);
    return x + y + {{(DATA_W-1){1'b0}}, cin};
  endfunction

  // signed overflow: both addends share a sign that the sum does not
  function automatic logic signed_ovf(
    input logic xs, input logic ys, input logic ss);
    return (xs == ys) && (ss != xs);
  endfunction

  logic [DATA_W-1:0] b_eff;

  assign b_eff = sub ? ~b : b;
  assign sum   = add_carry(a, b_eff, sub);
  assign sovf  = signed_ovf(a[MSB], b_eff[MSB], sum[MSB]);

endmodule

// File: rtl/exu_bitwise.sv
module exu_bitwise
  import exu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  alu_kind_e         kind,
  output logic [DATA_W-1:0] y
);

  logic sel_and, sel_or, sel_xor;

  assign sel_and = (kind == K_AND);
  assign sel_or  = (kind == K_OR);
  assign sel_xor = (kind == K_XOR);

  for (genvar i = 0; i < DATA_W; i++) begin : g_lane
    assign y[i] = (sel_and & (a[i] & b[i]))
                | (sel_or  & (a[i] | b[i]))
                | (sel_xor & (a[i] ^ b[i]));
  end

endmodule

// File: rtl/exu_alu.sv
module exu_alu
  import exu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [5:0]        insn_op,
  input  logic [4:0]        insn_rt,
  input  logic [15:0]       insn_low,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  output logic              out_valid,
  output logic              wr_en,
  output logic [4:0]        wr_idx,
  output logic [DATA_W-1:0] result,
  output logic              ovf_trap
);

  localparam int EXT_W = DATA_W - IMM_W;

  function automatic logic [DATA_W-1:0] imm_widen(
    input logic [IMM_W-1:0] imm, input logic sext);
    return {{EXT_W{sext & imm[IMM_W-1]}}, imm};
  endfunction

  dec_t              dec;
  logic [DATA_W-1:0] src_b;
  logic [DATA_W-1:0] arith_y;
  logic [DATA_W-1:0] logic_y;
  logic              arith_ovf;
  logic              is_arith;

  // named internal events, observed by the bound checker
  logic dec_legal;
  logic dec_trap_en;
  logic dec_logic;
  logic trap_hit;

  exu_decode u_dec (
    .op   (insn_op),
    .func (insn_low[5:0]),
    .rt   (insn_rt),
    .rd   (insn_low[15:11]),
    .dec  (dec)
  );

  assign src_b = dec.use_imm ? imm_widen(insn_low[IMM_W-1:0], dec.imm_sext) : opnd_b;

  exu_addsub #(.DATA_W(DATA_W)) u_add (
    .a    (opnd_a),
    .b    (src_b),
    .sub  (dec.kind == K_SUB),
    .sum  (arith_y),
    .sovf (arith_ovf)
  );

  exu_bitwise #(.DATA_W(DATA_W)) u_bit (
    .a    (opnd_a),
    .b    (src_b),
    .kind (dec.kind),
    .y    (logic_y)
  );

  assign is_arith    = (dec.kind == K_ADD) || (dec.kind == K_SUB);
  assign dec_legal   = dec.legal;
  assign dec_trap_en = dec.trap_en;
  assign dec_logic   = dec.legal && !is_arith;
  assign trap_hit    = in_valid && dec.legal && dec.trap_en && arith_ovf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      wr_en     <= 1'b0;
      ovf_trap  <= 1'b0;
      wr_idx    <= '0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      wr_en     <= in_valid && dec.legal && !trap_hit;
      ovf_trap  <= trap_hit;
      wr_idx    <= dec.dst;
      result    <= is_arith ? arith_y : logic_y;
    end
  end

endmodule

// File: rtl/exu_alu_chk.sv
module exu_alu_chk (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic out_valid,
  input logic wr_en,
  input logic ovf_trap,
  input logic dec_legal,
  input logic dec_trap_en,
  input logic dec_logic
);

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (!wr_en && !ovf_trap));

  // R2
  trap_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_trap |-> !wr_en);

  // R11
  beat_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R11
  no_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R3
  wrap_no_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && dec_legal && !dec_trap_en) |=> !ovf_trap);

  // R5
  logic_no_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && dec_logic) |=> (!ovf_trap && wr_en));

  // R9
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !dec_legal) |=> (!wr_en && !ovf_trap && out_valid));

endmodule

bind exu_alu exu_alu_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .out_valid   (out_valid),
  .wr_en       (wr_en),
  .ovf_trap    (ovf_trap),
  .dec_legal   (dec_legal),
  .dec_trap_en (dec_trap_en),
  .dec_logic   (dec_logic)
);

// File: tb/sim_exu_alu.sv
`timescale 1ns/1ps
module sim_exu_alu;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [5:0]  insn_op = '0;
  logic [4:0]  insn_rt = '0;
  logic [15:0] insn_low = '0;
  logic [31:0] opnd_a = '0;
  logic [31:0] opnd_b = '0;
  logic        out_valid, wr_en, ovf_trap;
  logic [4:0]  wr_idx;
  logic [31:0] result;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  exu_alu u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .insn_op(insn_op), .insn_rt(insn_rt), .insn_low(insn_low),
    .opnd_a(opnd_a), .opnd_b(opnd_b),
    .out_valid(out_valid), .wr_en(wr_en), .wr_idx(wr_idx),
    .result(result), .ovf_trap(ovf_trap)
  );

  typedef struct packed {
    logic        we;
    logic        ov;
    logic [4:0]  idx;
    logic [31:0] val;
  } exp_t;

  function automatic logic s_ovf(input longint r);
    return (r > 64'sd2147483647) || (r < -64'sd2147483648);
  endfunction

  function automatic longint sx(input logic [31:0] v);
    return longint'($signed(v));
  endfunction

  function automatic exp_t model(input logic [5:0] op, input logic [4:0] rt,
                                 input logic [15:0] lo, input logic [31:0] a,
                                 input logic [31:0] b);
    exp_t e;
    longint r;
    logic [31:0] se, ze;
    e = '0;
    se = {{16{lo[15]}}, lo};
    ze = {16'h0, lo};
    if (op == 6'd0) begin
      e.idx = lo[15:11];
      case (lo[5:0])
        6'h20: begin r = sx(a) + sx(b); e.val = a + b; e.ov = s_ovf(r); e.we = !e.ov; end
        6'h21: begin e.val = a + b; e.we = 1'b1; end
        6'h22: begin r = sx(a) - sx(b); e.val = a - b; e.ov = s_ovf(r); e.we = !e.ov; end
        6'h23: begin e.val = a - b; e.we = 1'b1; end
        6'h24: begin e.val = a & b; e.we = 1'b1; end
        6'h25: begin e.val = a | b; e.we = 1'b1; end
        6'h26: begin e.val = a ^ b; e.we = 1'b1; end
        default: ;
      endcase
    end else begin
      e.idx = rt;
      case (op)
        6'd8:  begin r = sx(a) + sx(se); e.val = a + se; e.ov = s_ovf(r); e.we = !e.ov; end
        6'd9:  begin e.val = a + se; e.we = 1'b1; end
        6'd12: begin e.val = a & ze; e.we = 1'b1; end
        6'd13: begin e.val = a | ze; e.we = 1'b1; end
        6'd14: begin e.val = a ^ ze; e.we = 1'b1; end
        default: ;
      endcase
    end
    return e;
  endfunction

  function automatic string req_of(input logic [5:0] op, input logic [5:0] fn);
    if (op == 6'd0) begin
      case (fn)
        6'h20: return "R2";
        6'h21: return "R3";
        6'h22, 6'h23: return "R4";
        6'h24, 6'h25, 6'h26: return "R5";
        default: return "R9";
      endcase
    end
    case (op)
      6'd8: return "R6";
      6'd9: return "R7";
      6'd12, 6'd13, 6'd14: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] got, input logic [31:0] want);
    total++;
    if (got !== want) begin
      bad++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, want);
    end
  endtask

  // drive one instruction at a falling edge, check after the next rising edge (R11)
  task automatic run(input logic [5:0] op, input logic [4:0] rt,
                     input logic [15:0] lo, input logic [31:0] a, input logic [31:0] b);
    exp_t e;
    string rq;
    e  = model(op, rt, lo, a, b);
    rq = req_of(op, lo[5:0]);
    in_valid = 1'b1; insn_op = op; insn_rt = rt; insn_low = lo;
    opnd_a = a; opnd_b = b;
    @(posedge clk);
    @(negedge clk);
    chk("R11", "out_valid", {31'd0, out_valid}, 32'd1);
    chk(rq, "wr_en", {31'd0, wr_en}, {31'd0, e.we});
    chk(rq, "ovf_trap", {31'd0, ovf_trap}, {31'd0, e.ov});
    if (e.we) begin
      chk(rq, "result", result, e.val);
      chk(rq, "wr_idx", {27'd0, wr_idx}, {27'd0, e.idx});
    end
  endtask

  function automatic logic [15:0] rform(input logic [4:0] rd, input logic [5:0] fn);
    return {rd, 5'd0, fn};
  endfunction

  function automatic logic [31:0] pick_opnd();
    logic [31:0] s;
    s = 32'($urandom() & 32'hff);
    case ($urandom() % 4)
      0: return 32'h7fffffff - s;
      1: return 32'h80000000 + s;
      default: return $urandom();
    endcase
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic [5:0] fns [7];
    logic [5:0] ops [5];
    void'($urandom(32'd2024));
    fns = '{6'h20, 6'h21, 6'h22, 6'h23, 6'h24, 6'h25, 6'h26};
    ops = '{6'd8, 6'd9, 6'd12, 6'd13, 6'd14};

    // R1: reset state
    repeat (2) @(negedge clk);
    chk("R1", "out_valid in reset", {31'd0, out_valid}, 32'd0);
    chk("R1", "wr_en in reset", {31'd0, wr_en}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "out_valid after reset", {31'd0, out_valid}, 32'd0);
    chk("R1", "ovf_trap after reset", {31'd0, ovf_trap}, 32'd0);

    // directed corners
    run(6'd0, 5'd0, rform(5'd8,  6'h20), 32'h7fffffff, 32'h7fffffff); // R2 trap
    run(6'd0, 5'd0, rform(5'd8,  6'h20), 32'h7fffffff, 32'h00000001); // R2 trap
    run(6'd0, 5'd0, rform(5'd9,  6'h20), 32'h80000000, 32'h7fffffff); // R2 no trap
    run(6'd0, 5'd0, rform(5'd10, 6'h21), 32'h7fffffff, 32'h00000001); // R3 wrap
    run(6'd0, 5'd0, rform(5'd11, 6'h22), 32'h80000000, 32'h00000001); // R4 trap
    run(6'd0, 5'd0, rform(5'd11, 6'h22), 32'h7fffffff, 32'hffffffff); // R4 trap
    run(6'd0, 5'd0, rform(5'd12, 6'h23), 32'h80000000, 32'h00000001); // R4 wrap
    run(6'd0, 5'd0, rform(5'd13, 6'h26), 32'hffffffff, 32'h7fffffff); // R5
    run(6'd8,  5'd7, 16'h0001, 32'h7fffffff, 32'h0);                  // R6 trap
    run(6'd8,  5'd7, 16'h8000, 32'h80000000, 32'h0);                  // R6 trap neg
    run(6'd8,  5'd7, 16'hffff, 32'h00000000, 32'h0);                  // R6 sext -1
    run(6'd9,  5'd6, 16'h0001, 32'h7fffffff, 32'h0);                  // R7 wrap
    run(6'd9,  5'd6, 16'h8000, 32'h00000010, 32'h0);                  // R7 sext
    run(6'd12, 5'd5, 16'hffff, 32'hffffffff, 32'h0);                  // R8 zext
    run(6'd13, 5'd5, 16'h8000, 32'h00000000, 32'h0);                  // R8 zext
    run(6'd14, 5'd5, 16'hf0f0, 32'hffff0000, 32'h0);                  // R8 zext
    run(6'd0, 5'd0, rform(5'd3, 6'h00), 32'h7fffffff, 32'h7fffffff);  // R9 funct
    run(6'd0, 5'd0, rform(5'd3, 6'h27), 32'h1, 32'h1);                // R9 funct
    run(6'd15, 5'd4, 16'h1234, 32'h7fffffff, 32'h7fffffff);           // R9 opcode

    // R10: idle cycle with overflowing trapping add on the inputs
    in_valid = 1'b0; insn_op = 6'd0; insn_low = rform(5'd8, 6'h20);
    opnd_a = 32'h7fffffff; opnd_b = 32'h7fffffff;
    @(posedge clk);
    @(negedge clk);
    chk("R10", "out_valid idle", {31'd0, out_valid}, 32'd0);
    chk("R10", "wr_en idle", {31'd0, wr_en}, 32'd0);
    chk("R10", "ovf_trap idle", {31'd0, ovf_trap}, 32'd0);

    // constrained random, back to back
    for (int n = 0; n < 400; n++) begin
      logic [31:0] a, b;
      logic [4:0]  rt, rd;
      a  = pick_opnd();
      b  = pick_opnd();
      rt = 5'($urandom());
      rd = 5'($urandom());
      if (($urandom() % 16) == 0)
        run(6'($urandom() | 32'h10), rt, 16'($urandom()), a, b);  // R9 random illegal opcode
      else if (($urandom() % 2) == 0)
        run(6'd0, rt, rform(rd, fns[$urandom() % 7]), a, b);
      else
        run(ops[$urandom() % 5], rt, 16'($urandom()), a, b);
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule